// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps a small processor core in reset after power is applied and lets it go once a chain of waits has finished. The chain starts when the power-on pulse ends. It then runs an optional power-up delay, counted in cycles of an always-running base clock. After that it runs an optional oscillator settle wait, which counts rising edges of the external crystal clock. The settle wait is used only in crystal-type oscillator modes. The power-up delay is skipped when its configuration bit is in the erased state. A brown-out event restarts the same chain. A power-on or brown-out event that arrives during any phase starts the chain again from the beginning.

The external active-low master reset pin, once synchronised, and the watchdog reset can also hold the core in reset. Neither of them starts the time-outs again. If the pin is still low after the waits have finished, raising it releases the core after the synchroniser latency alone. A two-bit cause register records whether a power-on or a brown-out event has happened since software last set the matching bit. The analog detectors and the oscillator are outside this block. They arrive as digital event inputs and a clock input.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_i` or `bor_i` is sampled high, `core_rst_o` is high from the next `clk_i` edge. Any such event, in any phase, restarts the whole time-out chain.
- R2: With the delay enabled (`pwrt_off_i`=0) and a non-crystal mode, `core_rst_o` falls on the (DELAY_CYCLES+1)-th rising `clk_i` edge at which `por_i` and `bor_i` are both sampled low.
- R3: With `pwrt_off_i`=1 and a non-crystal mode (`osc_mode_i` = 3 RC, 4 external clock, 5 internal oscillator, or any code from 6 to 7), `core_rst_o` falls on the first edge at which both events are low, so there is no time-out at all.
- R4: In the crystal modes (`osc_mode_i` = 0 LP, 1 XT, 2 HS), once the delay stage has finished (or straight away when it is disabled), release waits for OSC_CYCLES rising edges of `osc_clk_i`. The core is released within 3 `clk_i` edges of the last of those edges.
- R5: A brown-out event runs the same chain as a power-on event: the delay first, then the oscillator wait in crystal modes.
- R6: When `mclr_ni` goes low, `core_rst_o` rises on the third `clk_i` edge. The pin never restarts the time-outs. If the pin is still low after the time-outs have expired, raising it makes `core_rst_o` fall on the third edge.
- R7: `wdt_rst_i` sampled high drives `core_rst_o` high on that edge. Once the watchdog input is low again, the core is released on the next edge, and the time-outs do not restart.
- R8: `stat_o[1]` (power-on seen = 0) is cleared by a power-on event. Brown-out, master reset and watchdog events leave it unchanged.
- R9: `stat_o[0]` (brown-out seen = 0) is cleared by a brown-out event. Power-on, master reset and watchdog events leave it unchanged.
- R10: A software write (`stat_we_i`=1) sets each status bit whose `stat_wdata_i` bit is 1. Write data bits that are 0 change nothing. A clearing event in the same cycle wins over the write.
- R11: While `rst_ni` is low, `core_rst_o` is 1 and `stat_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-available base clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| osc_clk_i | input | 1 | External oscillator clock, counted as edges |
| por_i | input | 1 | Power-on pulse, active high |
| bor_i | input | 1 | Brown-out event, active high |
| mclr_ni | input | 1 | Master reset pin, active low, asynchronous |
| wdt_rst_i | input | 1 | Watchdog reset request |
| osc_mode_i | input | 3 | Oscillator mode code |
| pwrt_off_i | input | 1 | 1 = power-up delay disabled (erased state) |
| stat_we_i | input | 1 | Software write strobe for the status register |
| stat_wdata_i | input | 2 | Software write data; a 1 sets the matching bit |
| core_rst_o | output | 1 | Core reset, active high |
| stat_o | output | 2 | Reset-cause bits: [1] power-on, [0] brown-out |

## Verification
The assertions check on every cycle the rules that hold whatever the oscillator mode: events hold the core in reset, a held master reset pin or a watchdog request forces reset, each event clears its own cause bit, and a cause bit rises only after a software write. Release only ever follows a cycle with no event inputs. Exact time-out lengths, the count of oscillator edges, restart of the chain part-way through, and skipping stages by mode and configuration can only be shown by the bench scenarios. Those scenarios measure release edges against a gated oscillator whose edges the bench counts.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;

  typedef enum logic [2:0] {
    OSC_LP   = 3'd0,
    OSC_XT   = 3'd1,
    OSC_HS   = 3'd2,
    OSC_RC   = 3'd3,
    OSC_EXT  = 3'd4,
    OSC_INT  = 3'd5
  } osc_mode_e;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_e;

  localparam int STAT_W   = 2;
  localparam int STAT_POR = 1;
  localparam int STAT_BOR = 0;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode == OSC_LP) || (mode == OSC_XT) || (mode == OSC_HS);
  endfunction

endpackage

// File: rtl/pwrup_rst_sync.sv
module pwrup_rst_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[s] <= RST_VAL;
        else if (s == 0) sh_q[s] <= d_i;
        else sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pwrup_rst_delay.sv
module pwrup_rst_delay #(
  parameter int CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pwrup_rst_osc_cnt.sv
module pwrup_rst_osc_cnt #(
  parameter int CYCLES      = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_clk_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic osc_s, osc_prev_q, rise;
  logic [CW-1:0] cnt_q;

  pwrup_rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (osc_clk_i),
    .q_o   (osc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) osc_prev_q <= 1'b0;
    else         osc_prev_q <= osc_s;
  end

  assign rise = osc_s & ~osc_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (rise && (cnt_q != LAST))  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && rise && (cnt_q == LAST);
endmodule

// File: rtl/pwrup_rst_stat.sv
module pwrup_rst_stat
  import pwrup_rst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] clr, stat_q, stat_d;

  always_comb begin
    clr           = '0;
    clr[STAT_POR] = por_i;
    clr[STAT_BOR] = bor_i;
    // hardware clear beats a software set in the same cycle
    stat_d = (stat_q | ({STAT_W{we_i}} & wdata_i)) & ~clr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int DELAY_CYCLES = 256,
  parameter int OSC_CYCLES   = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_clk_i,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              mclr_ni,
  input  logic              wdt_rst_i,
  input  logic [2:0]        osc_mode_i,
  input  logic              pwrt_off_i,
  input  logic              stat_we_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic              core_rst_o,
  output logic [STAT_W-1:0] stat_o
);
  seq_state_e state_q, state_d;
  logic event_hit, xtal, mclr_s;
  logic dly_done, osc_done;
  logic core_rst_q;

  assign event_hit = por_i | bor_i;
  assign xtal      = is_crystal(osc_mode_i);

  pwrup_rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mclr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mclr_ni),
    .q_o   (mclr_s)
  );

  pwrup_rst_delay #(.CYCLES(DELAY_CYCLES)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == SEQ_DELAY),
    .done_o(dly_done)
  );

  pwrup_rst_osc_cnt #(.CYCLES(OSC_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_osc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_clk_i(osc_clk_i),
    .run_i    (state_q == SEQ_SETTLE),
    .done_o   (osc_done)
  );

  always_comb begin
    state_d = state_q;
    if (event_hit) begin
      state_d = SEQ_HOLD;
    end else begin
      unique case (state_q)
        SEQ_HOLD:   state_d = !pwrt_off_i ? SEQ_DELAY : (xtal ? SEQ_SETTLE : SEQ_RUN);
        SEQ_DELAY:  if (dly_done) state_d = xtal ? SEQ_SETTLE : SEQ_RUN;
        SEQ_SETTLE: if (osc_done) state_d = SEQ_RUN;
        SEQ_RUN:    state_d = SEQ_RUN;
        default:    state_d = SEQ_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_HOLD;
      core_rst_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      core_rst_q <= (state_d != SEQ_RUN) | ~mclr_s | wdt_rst_i;
    end
  end

  assign core_rst_o = core_rst_q;

  pwrup_rst_stat u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .por_i  (por_i),
    .bor_i  (bor_i),
    .we_i   (stat_we_i),
    .wdata_i(stat_wdata_i),
    .stat_o (stat_o)
  );
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       bor_i,
  input logic       mclr_ni,
  input logic       wdt_rst_i,
  input logic       stat_we_i,
  input logic [1:0] stat_wdata_i,
  input logic       core_rst_o,
  input logic [1:0] stat_o
);
  a_r1_event_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_i || bor_i) |=> core_rst_o);

  a_r2_release_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> $past(!por_i && !bor_i && !wdt_rst_i));

  a_r6_mclr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclr_ni && $past(!mclr_ni) && $past(!mclr_ni, 2)) |=> core_rst_o);

  a_r7_wdt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> core_rst_o);

  a_r8_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> !stat_o[1]);

  a_r9_bor_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_i |=> !stat_o[0]);

  a_r10_por_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[1]) |-> $past(stat_we_i && stat_wdata_i[1] && !por_i));

  a_r10_bor_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[0]) |-> $past(stat_we_i && stat_wdata_i[0] && !bor_i));
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_i       (por_i),
  .bor_i       (bor_i),
  .mclr_ni     (mclr_ni),
  .wdt_rst_i   (wdt_rst_i),
  .stat_we_i   (stat_we_i),
  .stat_wdata_i(stat_wdata_i),
  .core_rst_o  (core_rst_o),
  .stat_o      (stat_o)
);

// File: tb/pwrup_rst_seq_tb_top.sv
module pwrup_rst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OSC_HALF   = 37;
  localparam int DLY        = 64;
  localparam int OSC_N      = 1024;
  localparam int NVEC       = 10;
  // {we, wdata[1:0], por, bor, expected stat[1:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b1_11_00_11, 7'b0_00_00_11, 7'b1_00_00_11, 7'b0_00_10_01, 7'b1_10_00_11,
    7'b0_00_01_10, 7'b1_01_01_10, 7'b1_01_00_11, 7'b1_10_10_01, 7'b1_10_00_11
  };

  logic clk = 0, rst_n = 0, osc_clk = 0, osc_en = 0;
  logic por = 1, bor = 0, mclr_n = 1, wdt = 0, pwrt_off = 0, we = 0;
  logic [2:0] mode = 3'd4;
  logic [1:0] wd = 0;
  logic core_rst;
  logic [1:0] stat;
  int total = 0, bad = 0, osc_rises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever begin
    #(OSC_HALF);
    if (osc_en) osc_clk = ~osc_clk; else osc_clk = 1'b0;
  end
  always @(posedge osc_clk) osc_rises++;

  pwrup_rst_seq #(.DELAY_CYCLES(DLY), .OSC_CYCLES(OSC_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc_clk), .por_i(por), .bor_i(bor),
    .mclr_ni(mclr_n), .wdt_rst_i(wdt), .osc_mode_i(mode), .pwrt_off_i(pwrt_off),
    .stat_we_i(we), .stat_wdata_i(wd), .core_rst_o(core_rst), .stat_o(stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // event pulse; returns on the negedge at which the event drops
  task automatic pulse_event(input bit use_bor);
    @(negedge clk);
    osc_en = 0;
    if (use_bor) bor = 1; else por = 1;
    step(3);
    por = 0; bor = 0; osc_en = 1;
  endtask

  task automatic wait_release(input int limit, output int cyc);
    cyc = 0;
    while (core_rst && cyc < limit) begin
      step(1);
      cyc++;
    end
  endtask

  initial begin
    int cyc, r0;
    logic [1:0] snap;
    // R11 reset state
    step(3);
    check(core_rst == 1'b1, "R11 core_rst in reset", core_rst, 1);
    check(stat == 2'b00, "R11 stat in reset", stat, 0);
    rst_n = 1;
    step(2);
    por = 0;

    // table walk: R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      {we, wd, por, bor} = VEC[i][6:2];
      step(1);
      we = 0; wd = 0; por = 0; bor = 0;
      check(stat == VEC[i][1:0], "R8 R9 R10 status vector", stat, VEC[i][1:0]);
    end

    // R2 delay only, external clock mode
    mode = 3'd4; pwrt_off = 0;
    pulse_event(0);
    step(DLY);
    check(core_rst == 1'b1, "R2 held before delay end", core_rst, 1);
    step(1);
    check(core_rst == 1'b0, "R2 released after delay", core_rst, 0);

    // R3 no time-out in non-crystal modes
    pwrt_off = 1;
    for (int m = 3; m < 8; m++) begin
      mode = 3'(m);
      pulse_event(0);
      check(core_rst == 1'b1, "R3 held at drop", core_rst, 1);
      step(1);
      check(core_rst == 1'b0, "R3 immediate release", core_rst, m);
    end

    // R4 oscillator wait only, HS
    mode = 3'd2; pwrt_off = 1;
    pulse_event(0);
    r0 = osc_rises;
    wait_release(20000, cyc);
    check(osc_rises - r0 == OSC_N, "R4 osc edges before release", osc_rises - r0, OSC_N);

    // R4 delay plus oscillator wait, XT
    mode = 3'd1; pwrt_off = 0;
    pulse_event(0);
    step(DLY + 1);
    check(core_rst == 1'b1, "R4 settle follows delay", core_rst, 1);
    wait_release(20000, cyc);
    cyc += DLY + 1;
    check(cyc >= DLY + ((OSC_N-1)*2*OSC_HALF)/CLK_PERIOD - 2 &&
          cyc <= DLY + (OSC_N*2*OSC_HALF)/CLK_PERIOD + 6, "R4 total wait", cyc,
          DLY + (OSC_N*2*OSC_HALF)/CLK_PERIOD);

    // R5 brown-out runs the same chain, LP
    mode = 3'd0; pwrt_off = 0;
    we = 1; wd = 2'b11; step(1); we = 0; wd = 0;
    pulse_event(1);
    check(stat == 2'b10, "R5 R9 brown-out clears bit0 only", stat, 2);
    step(DLY + 1);
    check(core_rst == 1'b1, "R5 brown-out delay plus settle", core_rst, 1);
    wait_release(20000, cyc);
    check(core_rst == 1'b0, "R5 brown-out release", core_rst, 0);

    // R1 restart mid-delay
    mode = 3'd4; pwrt_off = 0;
    pulse_event(0);
    step(DLY/2);
    bor = 1; step(1); bor = 0;
    step(DLY);
    check(core_rst == 1'b1, "R1 restarted chain", core_rst, 1);
    step(1);
    check(core_rst == 1'b0, "R1 release after restart", core_rst, 0);

    // R6 master reset in normal operation
    we = 1; wd = 2'b11; step(1); we = 0; wd = 0;
    snap = stat;
    mclr_n = 0;
    step(2);
    check(core_rst == 1'b0, "R6 sync latency", core_rst, 0);
    step(1);
    check(core_rst == 1'b1, "R6 mclr asserts reset", core_rst, 1);
    step(DLY + 20);
    check(stat == snap, "R6 R8 R9 mclr leaves status", stat, snap);
    mclr_n = 1;
    step(2);
    check(core_rst == 1'b1, "R6 still in reset", core_rst, 1);
    step(1);
    check(core_rst == 1'b0, "R6 no time-out on pin release", core_rst, 0);

    // R6 pin held low past expiry of the time-outs
    mclr_n = 0;
    pulse_event(0);
    step(DLY + 10);
    check(core_rst == 1'b1, "R6 pin holds reset", core_rst, 1);
    mclr_n = 1;
    step(2);
    check(core_rst == 1'b1, "R6 pin release latency", core_rst, 1);
    step(1);
    check(core_rst == 1'b0, "R6 release at once", core_rst, 0);

    // R7 watchdog
    we = 1; wd = 2'b11; step(1); we = 0; wd = 0;
    wdt = 1; step(1); wdt = 0;
    check(core_rst == 1'b1, "R7 watchdog reset", core_rst, 1);
    step(1);
    check(core_rst == 1'b0, "R7 no time-out after watchdog", core_rst, 0);
    check(stat == 2'b11, "R7 R8 R9 watchdog leaves status", stat, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule